// File: doc/BRIEF.md
# Banked Indirect Configuration Port

This block holds the per-channel setup of a two-channel disk interface controller behind just two host-visible ports. The host first writes an 8-bit pointer that chooses one of two channel banks and a register index within that bank. It then moves 16-bit words through a data port, which lands on the register the pointer currently selects. Seven registers exist per bank: the command-block and control-block base addresses, a general control byte, a 10-bit read-ahead count split over two write-only registers, and two strobe-timing bytes.

If the pointer's step-enable bit is set, every data-port read or write moves the 3-bit index forward by one. This lets a driver stream a whole bank through the data port after a single pointer write. The remaining pointer bits carry bus-behaviour options that go straight out to the host interface logic. Every stored field is exported in parallel to the channel timing and control logic. Write-only fields are hidden from readback, and the FIFO-clear request is turned into a single-cycle strobe instead of being stored.

Top module: `chan_cfg_port`

## Requirements
- R1: After reset the pointer reads 0x50. Both banks then hold: index 1 = 0x01, index 5 = 0xF5, index 6 = 0xDE, index 2/3 fields cleared. Index 0 is 0x01F0 in bank 0 and 0x0170 in bank 1. Index 4 is 0x03F6 in bank 0 and 0x0376 in bank 1.
- R2: Pointer bit 3 selects the bank (0 = bank 0, 1 = bank 1) and bits 2-0 select the index. The data-port read value is the selected register, presented combinationally in the same cycle.
- R3: When pointer bit 7 is 1, every cycle with a data read or data write adds one to pointer bits 2-0 at the clock edge. Index 7 wraps to 0, and the bank bit and the other bits do not change. When bit 7 is 0, data accesses leave the pointer unchanged.
- R4: A pointer write in the same cycle as a data access loads the written pointer value, and the step is dropped.
- R5: Pointer bits 6, 4 and 5 drive posted_ws_o, devsel_med_o and burst_dis_o. Bit 5 is write-only and always reads back as 0.
- R6: Indices 0 and 4 store all 16 data bits, read back in full, and drive cmd_base_o and ctl_base_o.
- R7: Index 1 stores data bits 7-0 and drives gen_cfg_o. Readback shows bits 7-0 with bit 2 (power save, write-only) forced to 0 and bits 15-8 as 0.
- R8: Indices 2 and 3 always read as 0. ra_count_o is {index 3 bits 1-0, index 2 bits 7-0}. ra_en_o follows index 3 bit 7, and mode4_o follows index 3 bit 4.
- R9: Writing index 3 with data bit 6 set raises fifo_clr_o for that bank (bit 0 = bank 0, bit 1 = bank 1) in exactly the one cycle after the write edge. The bit is not stored.
- R10: Indices 5 and 6 store data bits 7-0 and drive data_tim_o and cmd_tim_o. Readback has bits 15-8 as 0.
- R11: Index 7 reads as 0, and writes to it change no exported field.
- R12: A data write changes only the bank selected by pointer bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ptr_wr | input | 1 | Pointer port write strobe |
| ptr_wdata | input | 8 | Pointer write value |
| ptr_rdata | output | 8 | Pointer readback (bit 5 masked) |
| dat_wr | input | 1 | Data port write strobe |
| dat_rd | input | 1 | Data port read strobe (drives index stepping) |
| dat_wdata | input | DATA_W | Data port write value |
| dat_rdata | output | DATA_W | Selected register readback |
| posted_ws_o | output | 1 | Posted write with one wait state |
| burst_dis_o | output | 1 | Master burst disabled |
| devsel_med_o | output | 1 | Medium device-select timing |
| cmd_base_o | output | 2*DATA_W | Command-block base, bank 1 in upper half |
| ctl_base_o | output | 2*DATA_W | Control-block base per bank |
| gen_cfg_o | output | 16 | General control byte per bank |
| ra_count_o | output | 20 | 10-bit read-ahead count per bank |
| ra_en_o | output | 2 | Read-ahead enable per bank |
| mode4_o | output | 2 | Fast-mode timing enable per bank |
| fifo_clr_o | output | 2 | One-cycle FIFO clear strobe per bank |
| data_tim_o | output | 16 | Data-port strobe timing per bank |
| cmd_tim_o | output | 16 | Command-port strobe timing per bank |

## Verification
Data-port readback is a combinational view of stored state, so it is due in the same cycle the pointer selects a register. Register writes, pointer loads and index steps appear one clock edge after the strobe. The FIFO-clear strobe is high only in the cycle following the write edge. The bench drives each strobe at a falling edge and removes it at the next falling edge, so it samples written state and the clear strobe exactly one edge after the stimulus, and it samples reads 1 ns after the strobe rises. It also sweeps every index of both banks with several data patterns through autoincrement, then checks readback, the index wrap and every exported field against a bench-side mask model.

// File: rtl/chan_cfg_pkg.sv
package chan_cfg_pkg;

   localparam int NUM_CHAN = 2;
   localparam int IDX_W    = 3;
   localparam int RA_LO_W  = 8;
   localparam int RA_HI_W  = 2;
   localparam int RA_W     = RA_LO_W + RA_HI_W;
   localparam int BYTE_W   = 8;

   typedef enum logic [IDX_W-1:0] {
      IX_CMD   = 3'd0,
      IX_GEN   = 3'd1,
      IX_RALO  = 3'd2,
      IX_RACFG = 3'd3,
      IX_CTL   = 3'd4,
      IX_DTIM  = 3'd5,
      IX_CTIM  = 3'd6,
      IX_NONE  = 3'd7
   } cfg_idx_e;

   // field order equals the bit positions software writes
   typedef struct packed {
      logic             autoinc;
      logic             posted_ws;
      logic             burst_dis;
      logic             devsel_med;
      logic             bank;
      logic [IDX_W-1:0] idx;
   } ptr_t;

   localparam logic [7:0] PTR_RST     = 8'h50;
   localparam logic [7:0] PTR_RD_MASK = 8'hDF;
   localparam logic [7:0] GEN_RD_MASK = 8'hFB;

endpackage

// File: rtl/chan_cfg_ptr.sv
module chan_cfg_ptr
   import chan_cfg_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr,
   input  logic [7:0] wdata,
   input  logic       step,
   output ptr_t       ptr_q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr_q <= ptr_t'(PTR_RST);
      end else if (wr) begin
         ptr_q <= ptr_t'(wdata);
      end else if (step && ptr_q.autoinc) begin
         ptr_q.idx <= ptr_q.idx + 1'b1;
      end
   end

endmodule

// File: rtl/chan_cfg_bank.sv
module chan_cfg_bank
   import chan_cfg_pkg::*;
#(
   parameter int                DATA_W   = 16,
   parameter logic [DATA_W-1:0] CMD_RST  = 'h01F0,
   parameter logic [DATA_W-1:0] CTL_RST  = 'h03F6,
   parameter logic [7:0]        GEN_RST  = 8'h01,
   parameter logic [7:0]        DTIM_RST = 8'hF5,
   parameter logic [7:0]        CTIM_RST = 8'hDE
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [IDX_W-1:0]   idx,
   input  logic [DATA_W-1:0]  wdata,
   output logic [DATA_W-1:0]  rdata,
   output logic [DATA_W-1:0]  cmd_base,
   output logic [DATA_W-1:0]  ctl_base,
   output logic [BYTE_W-1:0]  gen_cfg,
   output logic [RA_W-1:0]    ra_count,
   output logic               ra_en,
   output logic               mode4,
   output logic               fifo_clr,
   output logic [BYTE_W-1:0]  data_tim,
   output logic [BYTE_W-1:0]  cmd_tim
);

   cfg_idx_e              sel;
   logic [DATA_W-1:0]     cmd_q, ctl_q;
   logic [BYTE_W-1:0]     gen_q, dtim_q, ctim_q;
   logic [RA_LO_W-1:0]    ralo_q;
   logic [RA_HI_W-1:0]    rahi_q;
   logic                  ra_en_q, mode4_q, clr_q;

   assign sel = cfg_idx_e'(idx);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_q   <= CMD_RST;
         ctl_q   <= CTL_RST;
         gen_q   <= GEN_RST;
         dtim_q  <= DTIM_RST;
         ctim_q  <= CTIM_RST;
         ralo_q  <= '0;
         rahi_q  <= '0;
         ra_en_q <= 1'b0;
         mode4_q <= 1'b0;
         clr_q   <= 1'b0;
      end else begin
         clr_q <= wr_en && (sel == IX_RACFG) && wdata[6];
         if (wr_en) begin
            unique case (sel)
               IX_CMD:   cmd_q  <= wdata;
               IX_GEN:   gen_q  <= wdata[BYTE_W-1:0];
               IX_RALO:  ralo_q <= wdata[RA_LO_W-1:0];
               IX_RACFG: begin
                  ra_en_q <= wdata[7];
                  mode4_q <= wdata[4];
                  rahi_q  <= wdata[RA_HI_W-1:0];
               end
               IX_CTL:   ctl_q  <= wdata;
               IX_DTIM:  dtim_q <= wdata[BYTE_W-1:0];
               IX_CTIM:  ctim_q <= wdata[BYTE_W-1:0];
               default:  ;
            endcase
         end
      end
   end

   always_comb begin
      rdata = '0;
      unique case (sel)
         IX_CMD:  rdata = cmd_q;
         IX_GEN:  rdata = DATA_W'(gen_q & GEN_RD_MASK);
         IX_CTL:  rdata = ctl_q;
         IX_DTIM: rdata = DATA_W'(dtim_q);
         IX_CTIM: rdata = DATA_W'(ctim_q);
         default: rdata = '0;
      endcase
   end

   assign cmd_base = cmd_q;
   assign ctl_base = ctl_q;
   assign gen_cfg  = gen_q;
   assign ra_count = {rahi_q, ralo_q};
   assign ra_en    = ra_en_q;
   assign mode4    = mode4_q;
   assign fifo_clr = clr_q;
   assign data_tim = dtim_q;
   assign cmd_tim  = ctim_q;

endmodule

// File: rtl/chan_cfg_port.sv
module chan_cfg_port
   import chan_cfg_pkg::*;
#(
   parameter int                DATA_W     = 16,
   parameter logic [DATA_W-1:0] B0_CMD_RST = 'h01F0,
   parameter logic [DATA_W-1:0] B1_CMD_RST = 'h0170,
   parameter logic [DATA_W-1:0] B0_CTL_RST = 'h03F6,
   parameter logic [DATA_W-1:0] B1_CTL_RST = 'h0376,
   parameter logic [7:0]        GEN_RST    = 8'h01,
   parameter logic [7:0]        DTIM_RST   = 8'hF5,
   parameter logic [7:0]        CTIM_RST   = 8'hDE
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         ptr_wr,
   input  logic [7:0]                   ptr_wdata,
   output logic [7:0]                   ptr_rdata,
   input  logic                         dat_wr,
   input  logic                         dat_rd,
   input  logic [DATA_W-1:0]            dat_wdata,
   output logic [DATA_W-1:0]            dat_rdata,
   output logic                         posted_ws_o,
   output logic                         burst_dis_o,
   output logic                         devsel_med_o,
   output logic [2*DATA_W-1:0]          cmd_base_o,
   output logic [2*DATA_W-1:0]          ctl_base_o,
   output logic [2*8-1:0]               gen_cfg_o,
   output logic [2*10-1:0]              ra_count_o,
   output logic [1:0]                   ra_en_o,
   output logic [1:0]                   mode4_o,
   output logic [1:0]                   fifo_clr_o,
   output logic [2*8-1:0]               data_tim_o,
   output logic [2*8-1:0]               cmd_tim_o
);

   initial begin
      assert (DATA_W >= 16)
         else $error("chan_cfg_port: DATA_W must hold a 16-bit base address");
      assert (RA_W == 10 && NUM_CHAN == 2)
         else $error("chan_cfg_port: package layout mismatch");
   end

   ptr_t              ptr_q;
   logic [DATA_W-1:0] bank_rd [NUM_CHAN];

   chan_cfg_ptr u_ptr (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (ptr_wr),
      .wdata (ptr_wdata),
      .step  (dat_wr | dat_rd),
      .ptr_q (ptr_q)
   );

   for (genvar ch = 0; ch < NUM_CHAN; ch++) begin : g_bank
      localparam logic [DATA_W-1:0] CMD_R = (ch == 0) ? B0_CMD_RST : B1_CMD_RST;
      localparam logic [DATA_W-1:0] CTL_R = (ch == 0) ? B0_CTL_RST : B1_CTL_RST;

      chan_cfg_bank #(
         .DATA_W   (DATA_W),
         .CMD_RST  (CMD_R),
         .CTL_RST  (CTL_R),
         .GEN_RST  (GEN_RST),
         .DTIM_RST (DTIM_RST),
         .CTIM_RST (CTIM_RST)
      ) u_bank (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_en    (dat_wr && (ptr_q.bank == 1'(ch))),
         .idx      (ptr_q.idx),
         .wdata    (dat_wdata),
         .rdata    (bank_rd[ch]),
         .cmd_base (cmd_base_o[ch*DATA_W +: DATA_W]),
         .ctl_base (ctl_base_o[ch*DATA_W +: DATA_W]),
         .gen_cfg  (gen_cfg_o[ch*BYTE_W +: BYTE_W]),
         .ra_count (ra_count_o[ch*RA_W +: RA_W]),
         .ra_en    (ra_en_o[ch]),
         .mode4    (mode4_o[ch]),
         .fifo_clr (fifo_clr_o[ch]),
         .data_tim (data_tim_o[ch*BYTE_W +: BYTE_W]),
         .cmd_tim  (cmd_tim_o[ch*BYTE_W +: BYTE_W])
      );
   end

   assign dat_rdata    = bank_rd[ptr_q.bank];
   assign ptr_rdata    = ptr_q & PTR_RD_MASK;
   assign posted_ws_o  = ptr_q.posted_ws;
   assign burst_dis_o  = ptr_q.burst_dis;
   assign devsel_med_o = ptr_q.devsel_med;

endmodule

// File: rtl/chan_cfg_chk.sv
module chan_cfg_chk #(
   parameter int DATA_W = 16
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  ptr_wr,
   input logic                  dat_wr,
   input logic                  dat_rd,
   input logic                  wd6,
   input logic [7:0]            ptr_rdata,
   input logic [DATA_W-1:0]     dat_rdata,
   input logic [2*DATA_W-1:0]   cmd_base_o,
   input logic [2*DATA_W-1:0]   ctl_base_o,
   input logic [15:0]           gen_cfg_o,
   input logic [19:0]           ra_count_o,
   input logic [1:0]            ra_en_o,
   input logic [1:0]            mode4_o,
   input logic [1:0]            fifo_clr_o,
   input logic [15:0]           data_tim_o,
   input logic [15:0]           cmd_tim_o
);

   logic access;
   assign access = dat_wr | dat_rd;

   a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
      (access && !ptr_wr && ptr_rdata[7]) |=>
         (ptr_rdata[2:0] == 3'($past(ptr_rdata[2:0]) + 3'd1)) &&
         (ptr_rdata[7:3] == $past(ptr_rdata[7:3])));

   a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (access && !ptr_wr && !ptr_rdata[7]) |=> $stable(ptr_rdata));

   a_r5_wo_bit: assert property (@(posedge clk) disable iff (!rst_n)
      ptr_rdata[5] == 1'b0);

   a_r8_hidden: assert property (@(posedge clk) disable iff (!rst_n)
      (ptr_rdata[2:1] == 2'b01) |-> (dat_rdata == '0));

   a_r11_idx7_read: assert property (@(posedge clk) disable iff (!rst_n)
      (ptr_rdata[2:0] == 3'd7) |-> (dat_rdata == '0));

   a_r11_idx7_write: assert property (@(posedge clk) disable iff (!rst_n)
      (dat_wr && ptr_rdata[2:0] == 3'd7) |=>
         $stable(cmd_base_o) && $stable(ctl_base_o) && $stable(gen_cfg_o) &&
         $stable(ra_count_o) && $stable(ra_en_o) && $stable(mode4_o) &&
         $stable(data_tim_o) && $stable(cmd_tim_o) && (fifo_clr_o == 2'b00));

   a_r9_one_bank: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(fifo_clr_o));

   a_r9_cause0: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_clr_o[0] |-> $past(dat_wr && ptr_rdata[3:0] == 4'h3 && wd6));

   a_r9_cause1: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_clr_o[1] |-> $past(dat_wr && ptr_rdata[3:0] == 4'hB && wd6));

endmodule

bind chan_cfg_port chan_cfg_chk #(.DATA_W(DATA_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ptr_wr     (ptr_wr),
   .dat_wr     (dat_wr),
   .dat_rd     (dat_rd),
   .wd6        (dat_wdata[6]),
   .ptr_rdata  (ptr_rdata),
   .dat_rdata  (dat_rdata),
   .cmd_base_o (cmd_base_o),
   .ctl_base_o (ctl_base_o),
   .gen_cfg_o  (gen_cfg_o),
   .ra_count_o (ra_count_o),
   .ra_en_o    (ra_en_o),
   .mode4_o    (mode4_o),
   .fifo_clr_o (fifo_clr_o),
   .data_tim_o (data_tim_o),
   .cmd_tim_o  (cmd_tim_o)
);

// File: tb/test_chan_cfg_port.sv
`timescale 1ns/1ps
module test_chan_cfg_port;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ptr_wr = 1'b0;
   logic [7:0]  ptr_wdata = '0;
   logic [7:0]  ptr_rdata;
   logic        dat_wr = 1'b0;
   logic        dat_rd = 1'b0;
   logic [15:0] dat_wdata = '0;
   logic [15:0] dat_rdata;
   logic        posted_ws_o, burst_dis_o, devsel_med_o;
   logic [31:0] cmd_base_o, ctl_base_o;
   logic [15:0] gen_cfg_o, data_tim_o, cmd_tim_o;
   logic [19:0] ra_count_o;
   logic [1:0]  ra_en_o, mode4_o, fifo_clr_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   logic [15:0] mdl [2][8];

   always #4 clk = ~clk;

   chan_cfg_port i_chan_cfg_port (
      .clk(clk), .rst_n(rst_n), .ptr_wr(ptr_wr), .ptr_wdata(ptr_wdata),
      .ptr_rdata(ptr_rdata), .dat_wr(dat_wr), .dat_rd(dat_rd),
      .dat_wdata(dat_wdata), .dat_rdata(dat_rdata),
      .posted_ws_o(posted_ws_o), .burst_dis_o(burst_dis_o),
      .devsel_med_o(devsel_med_o), .cmd_base_o(cmd_base_o),
      .ctl_base_o(ctl_base_o), .gen_cfg_o(gen_cfg_o),
      .ra_count_o(ra_count_o), .ra_en_o(ra_en_o), .mode4_o(mode4_o),
      .fifo_clr_o(fifo_clr_o), .data_tim_o(data_tim_o), .cmd_tim_o(cmd_tim_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] stor_mask(input int i);
      case (i)
         0, 4:    return 16'hFFFF;
         1, 2, 5, 6: return 16'h00FF;
         3:       return 16'h0093;
         default: return 16'h0000;
      endcase
   endfunction

   function automatic logic [15:0] rd_mask(input int i);
      case (i)
         0, 4:    return 16'hFFFF;
         1:       return 16'h00FB;
         5, 6:    return 16'h00FF;
         default: return 16'h0000;
      endcase
   endfunction

   function automatic logic [15:0] pat(input int p, input int ch, input int i);
      case (p)
         0:       return 16'hFFFF;
         1:       return 16'h0000;
         2:       return 16'hA5C3 ^ 16'(ch * 8 + i);
         3:       return 16'h5A3C ^ 16'(i * 16'h1111);
         default: return 16'(16'h01F0 + ch * 16'h80 + i * 16'h040F);
      endcase
   endfunction

   task automatic ptr_write(input logic [7:0] v);
      @(negedge clk);
      ptr_wr = 1'b1; ptr_wdata = v;
      @(negedge clk);
      ptr_wr = 1'b0;
   endtask

   task automatic dat_write(input logic [15:0] v);
      @(negedge clk);
      dat_wr = 1'b1; dat_wdata = v;
      @(negedge clk);
      dat_wr = 1'b0;
   endtask

   task automatic dat_read(output logic [15:0] v);
      @(negedge clk);
      dat_rd = 1'b1;
      #1 v = dat_rdata;
      @(negedge clk);
      dat_rd = 1'b0;
   endtask

   task automatic chk_exports(input string tag);
      for (int ch = 0; ch < 2; ch++) begin
         chk({tag, " R6 cmd"},  cmd_base_o[ch*16 +: 16], mdl[ch][0]);
         chk({tag, " R6 ctl"},  ctl_base_o[ch*16 +: 16], mdl[ch][4]);
         chk({tag, " R7 gen"},  gen_cfg_o[ch*8 +: 8],    mdl[ch][1][7:0]);
         chk({tag, " R8 cnt"},  ra_count_o[ch*10 +: 10], {mdl[ch][3][1:0], mdl[ch][2][7:0]});
         chk({tag, " R8 en"},   ra_en_o[ch],             mdl[ch][3][7]);
         chk({tag, " R8 m4"},   mode4_o[ch],             mdl[ch][3][4]);
         chk({tag, " R10 dt"},  data_tim_o[ch*8 +: 8],   mdl[ch][5][7:0]);
         chk({tag, " R10 ct"},  cmd_tim_o[ch*8 +: 8],    mdl[ch][6][7:0]);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog act=hung exp=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [15:0] r;
      for (int ch = 0; ch < 2; ch++) begin
         mdl[ch][0] = ch ? 16'h0170 : 16'h01F0;
         mdl[ch][1] = 16'h0001;
         mdl[ch][2] = 16'h0000;
         mdl[ch][3] = 16'h0000;
         mdl[ch][4] = ch ? 16'h0376 : 16'h03F6;
         mdl[ch][5] = 16'h00F5;
         mdl[ch][6] = 16'h00DE;
         mdl[ch][7] = 16'h0000;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 ptr", ptr_rdata, 8'h50);
      chk("R1 ws",  posted_ws_o, 1'b1);
      chk("R1 dev", devsel_med_o, 1'b1);
      chk("R1 bd",  burst_dis_o, 1'b0);
      chk("R1 clr", fifo_clr_o, 2'b00);
      chk_exports("R1");
      for (int ch = 0; ch < 2; ch++)
         for (int i = 0; i < 8; i++) begin
            ptr_write(8'(ch * 8 + i));
            chk("R2 ptr", ptr_rdata, 8'(ch * 8 + i));
            dat_read(r);
            chk("R1 read", r, mdl[ch][i] & rd_mask(i));
            chk("R3 hold", ptr_rdata, 8'(ch * 8 + i));
         end

      // R5 pointer option bits
      ptr_write(8'hFF);
      chk("R5 rd", ptr_rdata, 8'hDF);
      chk("R5 opts", {posted_ws_o, burst_dis_o, devsel_med_o}, 3'b111);
      ptr_write(8'h00);
      chk("R5 rd0", ptr_rdata, 8'h00);
      chk("R5 opts0", {posted_ws_o, burst_dis_o, devsel_med_o}, 3'b000);

      // autoincrement sweeps over both banks
      for (int p = 0; p < 5; p++) begin
         for (int ch = 0; ch < 2; ch++) begin
            ptr_write(8'h80 | 8'(ch * 8));
            for (int i = 0; i < 8; i++) begin
               logic [15:0] v;
               v = pat(p, ch, i);
               dat_write(v);
               mdl[ch][i] = v & stor_mask(i);
               chk("R9 strobe", fifo_clr_o,
                   (i == 3 && v[6]) ? 2'(1 << ch) : 2'b00);
            end
            chk("R3 wrap", ptr_rdata, 8'h80 | 8'(ch * 8));
            chk_exports("R12");
            for (int i = 0; i < 8; i++) begin
               dat_read(r);
               chk("R2 read", r, mdl[ch][i] & rd_mask(i));
            end
            chk("R3 wrap rd", ptr_rdata, 8'h80 | 8'(ch * 8));
         end
      end

      // R4 pointer write beats step
      ptr_write(8'h8C);
      @(negedge clk);
      ptr_wr = 1'b1; ptr_wdata = 8'h82; dat_rd = 1'b1;
      @(negedge clk);
      ptr_wr = 1'b0; dat_rd = 1'b0;
      chk("R4 ptr", ptr_rdata, 8'h82);

      // R9 single-cycle strobe, bit not stored
      ptr_write(8'h03);
      dat_write(16'h0040);
      mdl[0][3] = 16'h0000;
      chk("R9 pulse", fifo_clr_o, 2'b01);
      @(negedge clk);
      chk("R9 drop", fifo_clr_o, 2'b00);
      chk_exports("R9");
      dat_read(r);
      chk("R8 read", r, 16'h0000);

      // R11 index 7
      ptr_write(8'h0F);
      dat_write(16'hFFFF);
      chk("R11 clr", fifo_clr_o, 2'b00);
      chk_exports("R11");
      dat_read(r);
      chk("R11 read", r, 16'h0000);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule